// File: doc/BRIEF.md
# One-Time-Programmable Security Area Guard

This block owns a 1024-byte one-time-programmable security area that lives beside a main memory array. The area is made of 32 regions of 32 bytes each. Region 0 carries three things at fixed places: a factory random value in its first 16 bytes, a 32-bit lock field in the next 4 bytes, and 12 reserved bytes that the host may still program. Cells can only be cleared, never set again, and nothing erases the area.

The area is reachable only while an overlay mode is active. An enter pulse chooses the sector that the area covers, and an exit pulse hands every access back to the main array. While the overlay is active, program requests carry an address and a byte. The block decides whether each request is silently dropped because the freeze input is low, rejected because its region is locked, rejected because it would clear a factory bit, or committed as the AND of the old and new byte. A sticky error flag records rejections. Reads that hit the covered sector are served from the area. All other reads are marked for the main array, and the array's byte is returned.

Top module: `otp_guard`

## Requirements
- R1: After reset, mode_active, status_err, pgm_done and rd_valid are 0. Bytes 0 to 15 read back FACTORY_SEED[8*i +: 8] for byte i, and every other byte reads 0xFF.
- R2: An enter_req pulse latches enter_sector and raises mode_active on the next cycle. An exit_req pulse clears mode_active on the next cycle, and exit wins when both arrive together. A program request while mode_active is 0 changes nothing and gives no pgm_done.
- R3: Every read request gives rd_valid exactly one cycle later. A read is served from the area when mode_active is 1 and rd_addr[ADDR_W-1:SECT_LSB] equals the latched sector: offsets below 1024 return the stored byte and higher offsets in that sector return 0x00. Any other read drives rd_to_array high in the request cycle and returns the array_rd_data sampled in that cycle.
- R4: A committed program stores old AND new, so bits only go from 1 to 0. Repeated programs of the same byte accumulate.
- R5: Program addresses use only bits 9:0. Higher bits, including the sector bits, are ignored.
- R6: A program to bytes 0 to 15 whose data has any 0 bit is rejected: the byte is unchanged and status_err goes to 1. Data 0xFF there is accepted without error.
- R7: Byte 16+k bit b is the lock bit of region 8*k+b. Region r covers bytes 32*r to 32*r+31. A program to a region whose lock bit is 0 is rejected with status_err set and the byte unchanged. This check comes before the factory-byte check.
- R8: Bytes 20 to 31 accept programming like ordinary bytes.
- R9: While freeze_n is 0, a program request changes no byte and leaves status_err unchanged, but still pulses pgm_done.
- R10: Every program request made while mode_active is 1 yields a pgm_done pulse exactly one cycle wide, in the next cycle, whatever its outcome.
- R11: status_err stays set until clr_status is pulsed. If a rejection and clr_status arrive in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enter_req | input | 1 | Enter overlay mode pulse |
| enter_sector | input | ADDR_W-SECT_LSB | Sector covered by the area while in overlay mode |
| exit_req | input | 1 | Leave overlay mode pulse |
| freeze_n | input | 1 | 0 blocks all programming without error |
| clr_status | input | 1 | Clears the sticky error flag |
| pgm_req | input | 1 | Program request strobe |
| pgm_addr | input | ADDR_W | Program byte address (bits 9:0 used) |
| pgm_data | input | 8 | Program data byte |
| rd_req | input | 1 | Read request strobe |
| rd_addr | input | ADDR_W | Read byte address |
| array_rd_data | input | 8 | Byte from the main array for pass-through reads |
| mode_active | output | 1 | Overlay mode is active |
| pgm_done | output | 1 | One-cycle completion pulse per program request |
| status_err | output | 1 | Sticky program error flag |
| rd_to_array | output | 1 | Current read goes to the main array |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |

## Verification
A wrong lock or factory decision shows up at the ports in the cycle after the request. status_err takes the wrong value, and a read issued next returns a byte that either changed when it should have been kept or stayed the same when it should have cleared. A stale overlay sector or mode bit shows up in the same cycle as the read, through rd_to_array, and one cycle later through rd_data, which then carries the array byte instead of the area byte or the reverse. Bits that are wrongly set back to 1 in storage stay hidden until that address is read. For that reason, every program in the bench is followed by a read-back.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int OTP_BYTES     = 1024;
  localparam int REGION_BYTES  = 32;
  localparam int OTP_AW        = $clog2(OTP_BYTES);
  localparam int REGION_AW     = $clog2(REGION_BYTES);
  localparam int NUM_REGIONS   = OTP_BYTES / REGION_BYTES;
  localparam int FACTORY_BYTES = 16;
  localparam int FACTORY_AW    = $clog2(FACTORY_BYTES);
  localparam int LOCK_BASE     = 16;
  localparam int LOCK_BYTES    = NUM_REGIONS / 8;

  typedef logic [7:0]        byte_t;
  typedef logic [OTP_AW-1:0] otp_addr_t;

  typedef enum logic [1:0] {
    VERDICT_IDLE   = 2'd0,
    VERDICT_WRITE  = 2'd1,
    VERDICT_REJECT = 2'd2,
    VERDICT_SILENT = 2'd3
  } verdict_e;

  function automatic byte_t init_byte(input logic [8*FACTORY_BYTES-1:0] seed, input int idx);
    byte_t b;
    b = 8'hFF;
    for (int i = 0; i < FACTORY_BYTES; i++) begin
      if (i == idx) b = seed[8*i +: 8];
    end
    return b;
  endfunction
endpackage

// File: rtl/otp_overlay.sv
module otp_overlay
  import otp_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 13,
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_req,
  input  logic [SECT_W-1:0] enter_sector,
  input  logic              exit_req,
  input  logic              pgm_req,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              active,
  output logic              pgm_ok,
  output logic              rd_hit,
  output logic              rd_in_range,
  output logic              rd_to_array
);
  logic              active_d, active_q;
  logic [SECT_W-1:0] sector_d, sector_q;
  logic              sector_match;

  always_comb begin
    active_d = active_q;
    sector_d = sector_q;
    if (exit_req) begin
      active_d = 1'b0;
    end else if (enter_req) begin
      active_d = 1'b1;
      sector_d = enter_sector;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sector_q <= '0;
    end else begin
      active_q <= active_d;
      sector_q <= sector_d;
    end
  end

  assign sector_match = (rd_addr[ADDR_W-1:SECT_LSB] == sector_q);
  assign active       = active_q;
  assign pgm_ok       = pgm_req & active_q;
  assign rd_hit       = rd_req & active_q & sector_match;
  assign rd_in_range  = (rd_addr[SECT_LSB-1:OTP_AW] == '0);
  assign rd_to_array  = rd_req & ~(active_q & sector_match);

  assert_exit_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |=> !active);
  assert_enter_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_req && !exit_req) |=> active);
endmodule

// File: rtl/otp_check.sv
module otp_check
  import otp_pkg::*;
(
  input  logic                   req,
  input  logic                   freeze_n,
  input  otp_addr_t              addr,
  input  byte_t                  data,
  input  logic [NUM_REGIONS-1:0] lock_vec,
  output verdict_e               verdict
);
  logic [OTP_AW-REGION_AW-1:0] region;
  logic                        region_locked;
  logic                        factory_hit;
  logic                        clears_bits;

  assign region        = addr[OTP_AW-1:REGION_AW];
  assign region_locked = ~lock_vec[region];
  assign factory_hit   = (addr[OTP_AW-1:FACTORY_AW] == '0);
  assign clears_bits   = (data != 8'hFF);

  always_comb begin
    verdict = VERDICT_IDLE;
    if (req) begin
      if (!freeze_n)                       verdict = VERDICT_SILENT;
      else if (region_locked)              verdict = VERDICT_REJECT;
      else if (factory_hit && clears_bits) verdict = VERDICT_REJECT;
      else                                 verdict = VERDICT_WRITE;
    end
  end

  always_comb begin
    if (req && freeze_n && region_locked)
      assert_lock_rejects_R7: assert (verdict == VERDICT_REJECT);
  end
endmodule

// File: rtl/otp_store.sv
module otp_store
  import otp_pkg::*;
#(
  parameter logic [8*FACTORY_BYTES-1:0] FACTORY_SEED = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  otp_addr_t              wr_addr,
  input  byte_t                  wr_data,
  input  otp_addr_t              rd_addr,
  output byte_t                  rd_byte,
  output logic [NUM_REGIONS-1:0] lock_vec
);
  byte_t mem_q [OTP_BYTES];
  byte_t old_byte;

  for (genvar g = 0; g < OTP_BYTES; g++) begin : g_cell
    logic  cell_en;
    byte_t cell_d;
    assign cell_en = wr_en && (wr_addr == otp_addr_t'(g));
    assign cell_d  = mem_q[g] & wr_data;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[g] <= init_byte(FACTORY_SEED, g);
      else if (cell_en) mem_q[g] <= cell_d;
    end
  end

  for (genvar l = 0; l < LOCK_BYTES; l++) begin : g_lock
    assign lock_vec[8*l +: 8] = mem_q[LOCK_BASE + l];
  end

  assign rd_byte  = mem_q[rd_addr];
  assign old_byte = mem_q[wr_addr];

  assert_and_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((mem_q[$past(wr_addr)] & ~$past(old_byte)) == 8'h00));
endmodule

// File: rtl/otp_guard.sv
module otp_guard
  import otp_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 13,
  parameter logic [8*FACTORY_BYTES-1:0] FACTORY_SEED = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_req,
  input  logic [SECT_W-1:0] enter_sector,
  input  logic              exit_req,
  input  logic              freeze_n,
  input  logic              clr_status,
  input  logic              pgm_req,
  input  logic [ADDR_W-1:0] pgm_addr,
  input  logic [7:0]        pgm_data,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        array_rd_data,
  output logic              mode_active,
  output logic              pgm_done,
  output logic              status_err,
  output logic              rd_to_array,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic                   pgm_ok, rd_hit, rd_in_range;
  logic [NUM_REGIONS-1:0] lock_vec;
  verdict_e               verdict;
  byte_t                  store_byte;
  otp_addr_t              pgm_off;

  assign pgm_off = pgm_addr[OTP_AW-1:0];

  otp_overlay #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) u_overlay (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .enter_req    (enter_req),
    .enter_sector (enter_sector),
    .exit_req     (exit_req),
    .pgm_req      (pgm_req),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .active       (mode_active),
    .pgm_ok       (pgm_ok),
    .rd_hit       (rd_hit),
    .rd_in_range  (rd_in_range),
    .rd_to_array  (rd_to_array)
  );

  otp_check u_check (
    .req      (pgm_ok),
    .freeze_n (freeze_n),
    .addr     (pgm_off),
    .data     (pgm_data),
    .lock_vec (lock_vec),
    .verdict  (verdict)
  );

  otp_store #(.FACTORY_SEED(FACTORY_SEED)) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (verdict == VERDICT_WRITE),
    .wr_addr  (pgm_off),
    .wr_data  (pgm_data),
    .rd_addr  (rd_addr[OTP_AW-1:0]),
    .rd_byte  (store_byte),
    .lock_vec (lock_vec)
  );

  logic  status_d, status_q;
  logic  done_d, done_q;
  logic  rvalid_d, rvalid_q;
  byte_t rdata_d, rdata_q;

  always_comb begin
    status_d = status_q;
    if (clr_status)                status_d = 1'b0;
    if (verdict == VERDICT_REJECT) status_d = 1'b1;
    done_d   = pgm_ok;
    rvalid_d = rd_req;
    rdata_d  = rdata_q;
    if (rd_req) begin
      if (!rd_hit)          rdata_d = array_rd_data;
      else if (rd_in_range) rdata_d = store_byte;
      else                  rdata_d = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      status_q <= 1'b0;
      done_q   <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= 8'h00;
    end else begin
      status_q <= status_d;
      done_q   <= done_d;
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  assign status_err = status_q;
  assign pgm_done   = done_q;
  assign rd_valid   = rvalid_q;
  assign rd_data    = rdata_q;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pgm_req && mode_active) |=> pgm_done);
  assert_no_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mode_active |=> !pgm_done);
  assert_freeze_silent_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pgm_req && !freeze_n && !clr_status) |=> $stable(status_err));
  assert_sticky_err_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (status_err && !clr_status) |=> status_err);
  assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_req |=> rd_valid);
endmodule

// File: tb/sim_otp_guard.sv
module sim_otp_guard;
  localparam int ADDR_W   = 24;
  localparam int SECT_LSB = 13;
  localparam int SECT_W   = ADDR_W - SECT_LSB;
  localparam logic [127:0] SEED = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              enter_req, exit_req, freeze_n, clr_status;
  logic [SECT_W-1:0] enter_sector;
  logic              pgm_req, rd_req;
  logic [ADDR_W-1:0] pgm_addr, rd_addr;
  logic [7:0]        pgm_data, array_rd_data;
  logic              mode_active, pgm_done, status_err, rd_to_array, rd_valid;
  logic [7:0]        rd_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  otp_guard #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .FACTORY_SEED(SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .enter_sector(enter_sector),
    .exit_req(exit_req), .freeze_n(freeze_n), .clr_status(clr_status),
    .pgm_req(pgm_req), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .array_rd_data(array_rd_data),
    .mode_active(mode_active), .pgm_done(pgm_done), .status_err(status_err),
    .rd_to_array(rd_to_array), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [ADDR_W-1:0] at(input int sect, input int off);
    return ADDR_W'(sect * (1 << SECT_LSB) + off);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_pgm(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                        input bit exp_done, input bit exp_err, input string tag);
    @(negedge clk);
    pgm_req = 1'b1; pgm_addr = a; pgm_data = d;
    @(negedge clk);
    pgm_req = 1'b0;
    chk(pgm_done == exp_done, {tag, " done"}, pgm_done, exp_done);
    chk(status_err == exp_err, {tag, " status"}, status_err, exp_err);
  endtask

  task automatic do_rd(input logic [ADDR_W-1:0] a, input logic [7:0] exp,
                       input bit exp_arr, input string tag);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a;
    #1;
    chk(rd_to_array == exp_arr, {tag, " route"}, rd_to_array, exp_arr);
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_valid == 1'b1, {tag, " valid"}, rd_valid, 1);
    chk(rd_data == exp, {tag, " data"}, rd_data, exp);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_status = 1'b1;
    @(negedge clk); clr_status = 1'b0;
  endtask

  task automatic t_reset();
    chk(mode_active == 0, "R1 mode", mode_active, 0);
    chk(status_err == 0, "R1 status", status_err, 0);
    chk(pgm_done == 0, "R1 done", pgm_done, 0);
    chk(rd_valid == 0, "R1 valid", rd_valid, 0);
  endtask

  task automatic t_inactive();
    do_rd(at(3, 40), 8'h5A, 1'b1, "R2 inactive read to array");
    do_pgm(at(3, 40), 8'h00, 1'b0, 1'b0, "R2 inactive program");
  endtask

  task automatic t_enter();
    @(negedge clk); enter_req = 1'b1; enter_sector = 3;
    @(negedge clk); enter_req = 1'b0;
    chk(mode_active == 1, "R2 enter", mode_active, 1);
    do_rd(at(3, 40), 8'hFF, 1'b0, "R1 blank byte after inactive program");
    do_rd(at(3, 5), SEED[8*5 +: 8], 1'b0, "R1 factory byte 5");
    do_rd(at(3, 1023), 8'hFF, 1'b0, "R1 last byte");
  endtask

  task automatic t_and();
    do_pgm(at(3, 40), 8'hF0, 1'b1, 1'b0, "R4 first program");
    do_rd(at(3, 40), 8'hF0, 1'b0, "R4 first value");
    do_pgm(at(3, 40), 8'h3C, 1'b1, 1'b0, "R4 second program");
    do_rd(at(3, 40), 8'h30, 1'b0, "R4 accumulated value");
  endtask

  task automatic t_alias();
    do_pgm(at(7, 1024 + 41), 8'h0F, 1'b1, 1'b0, "R5 aliased program");
    do_rd(at(3, 41), 8'h0F, 1'b0, "R5 aliased byte");
  endtask

  task automatic t_factory();
    do_pgm(at(3, 2), 8'hFE, 1'b1, 1'b1, "R6 clear factory bit");
    do_rd(at(3, 2), SEED[8*2 +: 8], 1'b0, "R6 factory unchanged");
    do_pgm(at(3, 40), 8'hFF, 1'b1, 1'b1, "R11 error kept after good program");
    pulse_clr();
    chk(status_err == 0, "R11 cleared", status_err, 0);
    do_pgm(at(3, 2), 8'hFF, 1'b1, 1'b0, "R6 all-ones accepted");
    do_rd(at(3, 2), SEED[8*2 +: 8], 1'b0, "R6 factory still intact");
  endtask

  task automatic t_reserved();
    do_pgm(at(3, 25), 8'h00, 1'b1, 1'b0, "R8 reserved program");
    do_rd(at(3, 25), 8'h00, 1'b0, "R8 reserved value");
  endtask

  task automatic t_lock();
    do_pgm(at(3, 17), 8'hFB, 1'b1, 1'b0, "R7 set lock for region 10");
    do_pgm(at(3, 323), 8'h00, 1'b1, 1'b1, "R7 locked region program");
    do_rd(at(3, 323), 8'hFF, 1'b0, "R7 locked byte unchanged");
    pulse_clr();
    do_pgm(at(3, 355), 8'h00, 1'b1, 1'b0, "R7 neighbour region open");
    do_rd(at(3, 355), 8'h00, 1'b0, "R7 neighbour written");
  endtask

  task automatic t_freeze();
    @(negedge clk); freeze_n = 1'b0;
    do_pgm(at(3, 60), 8'h00, 1'b1, 1'b0, "R9 frozen program silent");
    @(negedge clk); freeze_n = 1'b1;
    do_rd(at(3, 60), 8'hFF, 1'b0, "R9 frozen byte unchanged");
  endtask

  task automatic t_set_wins();
    @(negedge clk);
    clr_status = 1'b1; pgm_req = 1'b1; pgm_addr = at(3, 0); pgm_data = 8'h00;
    @(negedge clk);
    clr_status = 1'b0; pgm_req = 1'b0;
    chk(status_err == 1, "R11 set beats clear", status_err, 1);
    chk(pgm_done == 1, "R10 done on reject", pgm_done, 1);
    @(negedge clk);
    chk(pgm_done == 0, "R10 done one cycle", pgm_done, 0);
    pulse_clr();
  endtask

  task automatic t_reads();
    do_rd(at(3, 2000), 8'h00, 1'b0, "R3 beyond area in sector");
    do_rd(at(5, 40), 8'h5A, 1'b1, "R3 other sector to array");
  endtask

  task automatic t_exit();
    @(negedge clk); exit_req = 1'b1; enter_req = 1'b1; enter_sector = 3;
    @(negedge clk); exit_req = 1'b0; enter_req = 1'b0;
    chk(mode_active == 0, "R2 exit wins", mode_active, 0);
    do_rd(at(3, 40), 8'h5A, 1'b1, "R2 read after exit");
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; enter_req = 1'b0; exit_req = 1'b0; enter_sector = '0;
    freeze_n = 1'b1; clr_status = 1'b0; pgm_req = 1'b0; pgm_addr = '0;
    pgm_data = 8'hFF; rd_req = 1'b0; rd_addr = '0; array_rd_data = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_inactive();
    t_enter();
    t_and();
    t_alias();
    t_factory();
    t_reserved();
    t_lock();
    t_freeze();
    t_set_wins();
    t_reads();
    t_exit();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule